// File: doc/BRIEF.md
# Picture-in-Picture Field Capture and Decimation

This block takes the digitised inset video stream (6-bit samples, with a strobe before each line and a strobe before each field) and reduces it to a small picture for an inset window. The reduction factor is the same in both axes. It keeps one sample and one line in every four for an inset covering one sixteenth of the screen, or one in every three for one ninth of the screen. When the vertical filter is on, each kept line is replaced by a 1-2-1 weighted blend of itself and the two lines above it. Each result is presented on a synchronous write port that feeds an 8K by 8 field memory.

The picture size and filter selections are taken at each field strobe and hold for the whole field. A freeze request is also taken at the field strobe. A frozen field produces no memory writes, so the last field captured before the freeze stays intact. A field that is already being captured when freeze is requested is completed. A busy flag is high while the requested freeze state has not yet been applied, and it returns to 0 at the field strobe that applies it.

Top module: `pip_field_capture`

## Requirements
- R1: After reset, mem_we, mem_addr and write_busy are all 0.
- R2: With size select 0 latched, a sample is stored only if its position in the line (counting from 0 after the line strobe) satisfies j mod 4 = 3 and its line number in the field (counting from 0 after the field strobe) satisfies k mod 4 = 3. With the filter off, the stored byte is the sample shifted left by two bits, with bits 1:0 equal to 0.
- R3: With size select 1 latched, the same rule applies with modulus 3, so j mod 3 = 2 and k mod 3 = 2.
- R4: With the filter enabled, the stored byte for line k, column j is p(k-2,j) + 2·p(k-1,j) + p(k,j). This is the 1/4, 1/2, 1/4 average, scaled by four.
- R5: Within a field, stored samples go to consecutive addresses in row-major order, starting at address 0 after every field strobe. The address of kept line k, column j is (k div R)·(N div R) + (j div R), where R is the ratio and N is the number of samples in a line.
- R6: Size select and filter enable are sampled only on the field strobe. Changing them in the middle of a field has no effect on that field.
- R7: Freeze request is sampled on the field strobe. A frozen field produces no writes, so memory keeps the previous field. Raising the request in the middle of a field does not stop that field.
- R8: write_busy becomes 1 one cycle after freeze_req differs from the applied freeze state. It is 0 in the cycle after the field strobe that applies the request.
- R9: A cycle with pix_valid low is not a sample and does not advance the column count. A cycle in which a line or field strobe is high discards the sample in that cycle.
- R10: A write appears on the memory port exactly one cycle after the kept sample is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| field_start | input | 1 | One-cycle strobe before the first line of a field |
| line_start | input | 1 | One-cycle strobe before the first sample of a line |
| pix_valid | input | 1 | pix_data holds a sample this cycle |
| pix_data | input | 6 | Inset video sample |
| size_sel | input | 1 | 0: one-sixteenth area (ratio 4), 1: one-ninth area (ratio 3) |
| vfilt_en | input | 1 | Enable three-line vertical filter |
| freeze_req | input | 1 | Request that capture stop at the next field strobe |
| mem_we | output | 1 | Field memory write enable |
| mem_addr | output | 13 | Field memory write address |
| mem_wdata | output | 8 | Field memory write data |
| write_busy | output | 1 | A freeze or unfreeze request is still pending |

## Verification
The hardest situation to reach is the frozen field. Its effect is that nothing happens, so it can only be seen by showing that the memory still holds the previous field byte for byte. It also has to be preceded by a freeze request raised while a field is already being written. The stimulus table chains fields for this case. One field raises freeze half way through and must still be written in full. The next field is driven with a different pattern and must leave no writes, and the shadow memory is then compared against the reference for the earlier field. A later field releases the freeze while the busy flag is watched on both edges of the request.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int PH_W = 2;

  // Latched per-field configuration
  typedef struct packed {
    logic size;    // 0: ratio 4, 1: ratio 3
    logic filt;    // vertical filter on
    logic frozen;  // no writes this field
  } field_cfg_t;

  // Last phase value of a decimation period for the selected size
  function automatic logic [PH_W-1:0] ratio_last(input logic size);
    return size ? PH_W'(2) : PH_W'(3);
  endfunction
endpackage

// File: rtl/pfc_phase.sv
module pfc_phase
  import pfc_pkg::*;
#(
  parameter int COL_AW = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              field_start,
  input  logic              line_start,
  input  logic              pix_valid,
  input  logic              size_next,
  input  logic              size_cur,
  output logic              sample_ok,
  output logic              keep_col,
  output logic              keep_line,
  output logic [COL_AW-1:0] col_idx
);
  logic [PH_W-1:0] col_ph, line_ph, last;

  assign last      = ratio_last(size_cur);
  assign sample_ok = pix_valid && !field_start && !line_start;
  assign keep_col  = (col_ph == last);
  assign keep_line = (line_ph == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      col_ph  <= '0;
      line_ph <= ratio_last(1'b0);
      col_idx <= '0;
    end else if (field_start) begin
      // first line strobe of the field wraps this to 0
      col_ph  <= '0;
      line_ph <= ratio_last(size_next);
      col_idx <= '0;
    end else if (line_start) begin
      col_ph  <= '0;
      col_idx <= '0;
      line_ph <= keep_line ? '0 : line_ph + 1'b1;
    end else if (pix_valid) begin
      col_ph <= keep_col ? '0 : col_ph + 1'b1;
      if (keep_col) col_idx <= col_idx + 1'b1;
    end
  end

  p_phase_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (col_ph <= last) && (line_ph <= last));
endmodule

// File: rtl/pfc_vfilter.sv
module pfc_vfilter #(
  parameter int PIX_W  = 6,
  parameter int COL_AW = 7,
  parameter int OUT_W  = 8
) (
  input  logic              clk,
  input  logic              shift_en,
  input  logic [COL_AW-1:0] col_idx,
  input  logic [PIX_W-1:0]  pix,
  input  logic              filt_en,
  output logic [OUT_W-1:0]  value
);
  localparam int TAPS  = 2;
  localparam int DEPTH = 1 << COL_AW;
  localparam int EXT   = OUT_W - PIX_W;

  logic [PIX_W-1:0] tap [TAPS+1];
  assign tap[0] = pix;

  // One line buffer per previous line, holding only kept columns
  for (genvar g = 0; g < TAPS; g++) begin : g_line
    logic [PIX_W-1:0] line_mem [DEPTH];
    assign tap[g+1] = line_mem[col_idx];
    always_ff @(posedge clk) begin
      if (shift_en) line_mem[col_idx] <= tap[g];
    end
  end

  logic [OUT_W-1:0] oldest, middle, newest;
  assign oldest = {{EXT{1'b0}}, tap[2]};
  assign middle = {{EXT{1'b0}}, tap[1]};
  assign newest = {{EXT{1'b0}}, tap[0]};

  always_comb begin
    if (filt_en) value = oldest + (middle << 1) + newest;
    else         value = newest << 2;
  end
endmodule

// File: rtl/pfc_writer.sv
module pfc_writer
  import pfc_pkg::*;
#(
  parameter int MEM_AW = 13,
  parameter int MEM_DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              field_start,
  input  logic              freeze_req,
  input  logic              size_sel,
  input  logic              vfilt_en,
  input  logic              write_now,
  input  logic [MEM_DW-1:0] wdata_in,
  output field_cfg_t        cfg,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [MEM_DW-1:0] mem_wdata,
  output logic              write_busy
);
  logic [MEM_AW-1:0] addr_cnt;
  logic              first_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg        <= '0;
      addr_cnt   <= '0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      write_busy <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      if (field_start) begin
        cfg.frozen <= freeze_req;
        cfg.size   <= size_sel;
        cfg.filt   <= vfilt_en;
        addr_cnt   <= '0;
        write_busy <= 1'b0;
      end else begin
        write_busy <= (freeze_req != cfg.frozen);
        if (write_now && !cfg.frozen) begin
          mem_we    <= 1'b1;
          mem_addr  <= addr_cnt;
          mem_wdata <= wdata_in;
          addr_cnt  <= addr_cnt + 1'b1;
        end
      end
    end
  end

  // Checker state: first write of a field still to come
  always_ff @(posedge clk) begin
    if (rst || field_start) first_pend <= 1'b1;
    else if (mem_we)        first_pend <= 1'b0;
  end

  p_first_addr_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_we && first_pend) |-> (mem_addr == '0));
  p_busy_clear_r8: assert property (@(posedge clk) disable iff (rst)
    field_start |=> !write_busy);
  p_frozen_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    cfg.frozen |-> !mem_we);
endmodule

// File: rtl/pip_field_capture.sv
module pip_field_capture
  import pfc_pkg::*;
#(
  parameter int PIX_W  = 6,
  parameter int MEM_AW = 13,
  parameter int MEM_DW = 8,
  parameter int COL_AW = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              field_start,
  input  logic              line_start,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_data,
  input  logic              size_sel,
  input  logic              vfilt_en,
  input  logic              freeze_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [MEM_DW-1:0] mem_wdata,
  output logic              write_busy
);
  field_cfg_t        cfg;
  logic              sample_ok, keep_col, keep_line;
  logic [COL_AW-1:0] col_idx;
  logic [MEM_DW-1:0] value;

  pfc_phase #(.COL_AW(COL_AW)) u_phase (
    .clk        (clk),
    .rst        (rst),
    .field_start(field_start),
    .line_start (line_start),
    .pix_valid  (pix_valid),
    .size_next  (size_sel),
    .size_cur   (cfg.size),
    .sample_ok  (sample_ok),
    .keep_col   (keep_col),
    .keep_line  (keep_line),
    .col_idx    (col_idx)
  );

  pfc_vfilter #(.PIX_W(PIX_W), .COL_AW(COL_AW), .OUT_W(MEM_DW)) u_vfilter (
    .clk     (clk),
    .shift_en(sample_ok && keep_col),
    .col_idx (col_idx),
    .pix     (pix_data),
    .filt_en (cfg.filt),
    .value   (value)
  );

  pfc_writer #(.MEM_AW(MEM_AW), .MEM_DW(MEM_DW)) u_writer (
    .clk        (clk),
    .rst        (rst),
    .field_start(field_start),
    .freeze_req (freeze_req),
    .size_sel   (size_sel),
    .vfilt_en   (vfilt_en),
    .write_now  (sample_ok && keep_col && keep_line),
    .wdata_in   (value),
    .cfg        (cfg),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .write_busy (write_busy)
  );

  p_latency_r10: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(pix_valid));
  p_scaled_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !cfg.filt) |-> (mem_wdata[1:0] == 2'b00));
endmodule

// File: tb/test_pip_field_capture.sv
module test_pip_field_capture;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        field_start = 0, line_start = 0, pix_valid = 0;
  logic [5:0]  pix_data = '0;
  logic        size_sel = 0, vfilt_en = 0, freeze_req = 0;
  logic        mem_we;
  logic [12:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        write_busy;

  int tests = 0, fails = 0;
  logic [7:0] shadow [8192];
  int wr_count = 0;
  int first_addr = -1;
  bit applied_frz = 0;

  always #4 clk = ~clk;

  pip_field_capture i_pip_field_capture (
    .clk(clk), .rst(rst), .field_start(field_start), .line_start(line_start),
    .pix_valid(pix_valid), .pix_data(pix_data), .size_sel(size_sel),
    .vfilt_en(vfilt_en), .freeze_req(freeze_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .write_busy(write_busy)
  );

  always @(negedge clk) begin
    if (!rst && mem_we) begin
      if (wr_count == 0) first_addr = int'(mem_addr);
      shadow[mem_addr] = mem_wdata;
      wr_count++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pixel(int fid, int l, int c, bit pat);
    return pat ? 63 : ((l * 5 + c * 3 + fid * 11) % 64);
  endfunction

  // size, filt, frz, mid(2b), pat, nl(8b), np(8b)
  // mid: 0 none, 1 flip size/filter mid-field, 2 raise freeze mid-field
  localparam int NROWS = 8;
  localparam logic [31:0] ROWS [NROWS] = '{
    {1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 10'd0, 8'd16, 8'd24},
    {1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 10'd0, 8'd15, 8'd24},
    {1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 10'd0, 8'd16, 8'd20},
    {1'b1, 1'b1, 1'b0, 2'd1, 1'b0, 10'd0, 8'd12, 8'd21},
    {1'b1, 1'b1, 1'b0, 2'd0, 1'b1, 10'd0, 8'd9,  8'd9},
    {1'b0, 1'b1, 1'b0, 2'd2, 1'b0, 10'd0, 8'd16, 8'd16},
    {1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 10'd0, 8'd12, 8'd12},
    {1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 10'd0, 8'd15, 8'd18}
  };

  // reference of the last captured field
  bit ref_size, ref_filt, ref_pat;
  int ref_nl, ref_np, ref_fid;

  task automatic compare_mem(input string req);
    int r = ref_size ? 3 : 4;
    int bad = 0, a_act = 0, a_exp = 0;
    for (int k = r - 1; k < ref_nl; k += r) begin
      for (int j = r - 1; j < ref_np; j += r) begin
        int e;
        int addr = (k / r) * (ref_np / r) + (j / r);
        if (ref_filt)
          e = pixel(ref_fid, k - 2, j, ref_pat) + 2 * pixel(ref_fid, k - 1, j, ref_pat)
              + pixel(ref_fid, k, j, ref_pat);
        else
          e = 4 * pixel(ref_fid, k, j, ref_pat);
        if (int'(shadow[addr]) != e) begin
          if (bad == 0) begin a_act = int'(shadow[addr]); a_exp = e; end
          bad++;
        end
      end
    end
    chk(bad == 0, req, a_act, a_exp);
  endtask

  task automatic run_field(input int fid, input logic [31:0] row);
    bit sz = row[31], fl = row[30], fz = row[29], pat = row[26];
    int mid = int'(row[28:27]);
    int nl = int'(row[15:8]), np = int'(row[7:0]);
    int r = sz ? 3 : 4;
    int exp_w;
    size_sel = sz; vfilt_en = fl; freeze_req = fz;
    @(negedge clk); @(negedge clk);
    if (fz != applied_frz) chk(write_busy == 1'b1, "R8 pending", write_busy, 1);
    wr_count = 0; first_addr = -1;
    field_start = 1; @(negedge clk); field_start = 0;
    applied_frz = fz;
    chk(write_busy == 1'b0, "R8 applied", write_busy, 0);
    for (int l = 0; l < nl; l++) begin
      if (l == nl / 2 && mid == 1) begin size_sel = ~sz; vfilt_en = ~fl; end
      if (l == nl / 2 && mid == 2) freeze_req = 1'b1;
      line_start = 1; @(negedge clk); line_start = 0;
      if (l == nl / 2 && mid == 2) chk(write_busy == 1'b1, "R8 raise", write_busy, 1);
      for (int c = 0; c < np; c++) begin
        if (c == 5) begin
          pix_valid = 0; pix_data = 6'h2A; @(negedge clk);
        end
        pix_valid = 1; pix_data = 6'(pixel(fid, l, c, pat)); @(negedge clk);
      end
      pix_valid = 0;
    end
    @(negedge clk); @(negedge clk);
    exp_w = fz ? 0 : (nl / r) * (np / r);
    chk(wr_count == exp_w, fz ? "R7 frozen count" : (mid == 2 ? "R7 mid count" : "R5 count"),
        wr_count, exp_w);
    if (!fz) begin
      chk(first_addr == 0, "R5 first", first_addr, 0);
      ref_size = sz; ref_filt = fl; ref_pat = pat; ref_nl = nl; ref_np = np; ref_fid = fid;
      compare_mem(mid == 1 ? "R6 data" : (fl ? "R4 data" : (sz ? "R3 R9 data" : "R2 R9 data")));
    end else begin
      compare_mem("R7 held");
    end
    size_sel = sz; vfilt_en = fl;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_we == 0 && write_busy == 0 && mem_addr == 0, "R1 reset",
        int'({mem_we, write_busy, mem_addr != 0}), 0);
    rst = 0;
    @(negedge clk);
    chk(mem_we == 0, "R1 idle", mem_we, 0);

    // R10: 3x3 field at ratio 3, only sample (2,2) is kept
    size_sel = 1; vfilt_en = 0;
    field_start = 1; @(negedge clk); field_start = 0;
    for (int l = 0; l < 3; l++) begin
      line_start = 1; @(negedge clk); line_start = 0;
      for (int c = 0; c < 3; c++) begin
        pix_valid = 1; pix_data = 6'(10 + l * 10 + c * 1 + (l == 2 && c == 2 ? 1 : 0));
        @(negedge clk);
        if (l == 2 && c == 1) chk(mem_we == 0, "R10 before", mem_we, 0);
      end
      pix_valid = 0;
    end
    chk(mem_we == 1 && mem_addr == 0, "R10 write", mem_we, 1);
    chk(mem_wdata == 8'd132, "R10 data", mem_wdata, 132);
    @(negedge clk);
    chk(mem_we == 0, "R10 single", mem_we, 0);

    for (int i = 0; i < NROWS; i++) run_field(i + 1, ROWS[i]);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule